// File: doc/BRIEF.md
# Banked Network Controller Register Block

This block is the byte-wide host register interface of a legacy Ethernet controller. The host sees sixteen byte offsets. Offset 0 is always the command register. The two top bits of the command register pick a register page, and that page gives offsets 1 to 15 their meaning. The block stores these parameters and drives them out as plain ports:

- the receive ring limits, the boundary page and the current receive page;
- the transmit start page and the 16-bit transmit length;
- the remote DMA start address and the remote DMA byte count;
- the receive and data configuration bytes;
- the station address and the multicast hash filter.

The block owns the interrupt status and mask registers and drives a single level interrupt. External logic reports events through a set-vector input: received frames, errors, overwrite, counters and remote DMA completion. Software clears status by writing ones to the status register.

A transmit command completes at once. It gives a one-cycle start pulse, with the page and the length, to an external frame sender. It then records a successful send in the transmit status. Packet memory, the medium and the receive path sit outside the block.

Top module: `nic_page_regs`

## Requirements
- R1: After the synchronous reset the command register reads 0x01, the interrupt status reads 0x80, the irq output is low and the transmit start pulse is low.
- R2: A register access at offset 1 to 15 goes to the effective register {command[7:6], offset}. Page 0 holds ring start (1), ring stop (2), boundary (3), transmit page (4), transmit length low and high (5, 6), status (7), remote address low and high (8, 9), remote count low and high (10, 11), receive config (12), data config (14) and mask (15). Page 1 holds station bytes at 1 to 6, with byte i on station_addr[8i+7:8i], the current page at 7 and the multicast bytes at 8 to 15. Page 2 reads ring start at 1 and ring stop at 2.
- R3: The transmit length, the remote start address and the remote byte count are each written as a low byte and a high byte. A write to one byte leaves the other byte unchanged.
- R4: A command write with bit 0 (stop) clear clears status bit 7 (reset done). A command write with bit 0 set leaves it unchanged.
- R5: A command write with bit 0 clear and bit 3 or bit 4 (remote read or write) set sets status bit 6 on the same edge, but only when the remote byte count is 0.
- R6: A command write with bit 2 set and bit 0 clear gives a one-cycle tx_start with tx_page and tx_len. It sets transmit status (page 0 read offset 4) to 0x01, sets status bit 1 and stores the command with bit 2 cleared. With bit 0 set, no pulse occurs and the command is stored as written.
- R7: Writing the status register clears each of bits 6:0 that is 1 in the written value. Bit 7 is not affected.
- R8: irq is high exactly when (status AND mask AND 0x7F) is nonzero. It follows every change of status or mask on the same edge.
- R9: Page 0 reads 0x50 at offset 10 and 0x43 at offset 11. Page 3 reads 0x00 at 3 and 0x40 at 5 and 6. Every unmapped register reads 0x00.
- R10: evt_set bit n (n = 0..6) sets status bit n. A set wins over a clear from a status write in the same cycle.
- R11: rd_data is registered. It takes the addressed value on the edge where rd_en is high, and it holds while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 4 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| evt_set | input | 7 | External status set pulses, bit n sets status bit n |
| irq | output | 1 | Level interrupt |
| tx_start | output | 1 | One-cycle send request |
| tx_page | output | 8 | Transmit start page |
| tx_len | output | 16 | Transmit length in bytes |
| ring_start | output | 8 | Receive ring first page |
| ring_stop | output | 8 | Receive ring end page |
| bnry_pg | output | 8 | Boundary page |
| cur_pg | output | 8 | Current receive page |
| rdma_addr | output | 16 | Remote DMA start address |
| rdma_cnt | output | 16 | Remote DMA byte count |
| rcv_cfg | output | 8 | Receive configuration byte |
| data_cfg | output | 8 | Data configuration byte |
| station_addr | output | 48 | Station address, byte i at [8i+7:8i] |
| mcast_filter | output | 64 | Multicast filter, byte i at [8i+7:8i] |

## Verification
Some behaviours are checked on every cycle: the relation between irq and the masked status, that status bit 7 never sets outside reset, the clearing of reset-done and the zero-count DMA completion after a command write, that a send pulse comes with a set transmit bit and a cleared command bit, and that external events land in status. Only the directed scenarios can show the rest. These are page decoding, the byte merge of the 16-bit registers, the fixed read values, set-over-clear precedence, the suppression of a send while stopped, and the hold of rd_data between reads.

// File: rtl/nicr_pkg.sv
package nicr_pkg;
  // command register bit positions
  localparam int CMD_STP  = 0;
  localparam int CMD_STA  = 1;
  localparam int CMD_TXP  = 2;
  localparam int CMD_RRD  = 3;
  localparam int CMD_RWR  = 4;
  localparam int CMD_NDMA = 5;

  // interrupt status bit positions
  localparam int IS_TX  = 1;
  localparam int IS_RDC = 6;
  localparam int IS_RST = 7;

  localparam int CNT_W = 16;
  localparam int EVT_W = 7;

  localparam logic [7:0] CMD_RESET  = 8'h01;
  localparam logic [7:0] ISR_RESET  = 8'h80;
  localparam logic [7:0] ISR_WCMASK = 8'h7F;
  localparam logic [7:0] TSR_SENT   = 8'h01;

  // effective addresses {page, offset}
  localparam logic [5:0] A_PSTART = 6'h01;
  localparam logic [5:0] A_PSTOP  = 6'h02;
  localparam logic [5:0] A_BNRY   = 6'h03;
  localparam logic [5:0] A_TPG    = 6'h04;
  localparam logic [5:0] A_TCL    = 6'h05;
  localparam logic [5:0] A_TCH    = 6'h06;
  localparam logic [5:0] A_ISR    = 6'h07;
  localparam logic [5:0] A_RSL    = 6'h08;
  localparam logic [5:0] A_RSH    = 6'h09;
  localparam logic [5:0] A_RCL    = 6'h0A;
  localparam logic [5:0] A_RCH    = 6'h0B;
  localparam logic [5:0] A_RXC    = 6'h0C;
  localparam logic [5:0] A_DCF    = 6'h0E;
  localparam logic [5:0] A_IMR    = 6'h0F;
  localparam logic [5:0] A_STA    = 6'h11;
  localparam logic [5:0] A_CUR    = 6'h17;
  localparam logic [5:0] A_MC     = 6'h18;
  localparam logic [5:0] A_P2STA  = 6'h21;
  localparam logic [5:0] A_P2STP  = 6'h22;
  localparam logic [5:0] A_CFG0   = 6'h33;
  localparam logic [5:0] A_CFG2   = 6'h35;
  localparam logic [5:0] A_CFG3   = 6'h36;
endpackage

// File: rtl/nicr_cmd_ctrl.sv
module nicr_cmd_ctrl
  import nicr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [7:0]       wr_data,
  input  logic [CNT_W-1:0] rcnt,
  output logic [7:0]       cmd,
  output logic             start_wr,
  output logic             zero_dma,
  output logic             tx_start,
  output logic [7:0]       tsr
);
  localparam logic [7:0] TXP_CLR = ~(8'h01 << CMD_TXP);

  logic tx_go;

  always_comb begin
    start_wr = cmd_wr && !wr_data[CMD_STP];
    zero_dma = start_wr && (wr_data[CMD_RRD] || wr_data[CMD_RWR]) && (rcnt == '0);
    tx_go    = start_wr && wr_data[CMD_TXP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= CMD_RESET;
      tx_start <= 1'b0;
      tsr      <= 8'h00;
    end else begin
      tx_start <= tx_go;
      if (cmd_wr) cmd <= tx_go ? (wr_data & TXP_CLR) : wr_data;
      if (tx_go)  tsr <= TSR_SENT;
    end
  end
endmodule

// File: rtl/nicr_irq_ctrl.sv
module nicr_irq_ctrl
  import nicr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_wr,
  input  logic             clr_wr,
  input  logic [7:0]       wr_data,
  input  logic [EVT_W-1:0] set_in,
  input  logic             clr_rst,
  output logic [7:0]       status,
  output logic [7:0]       mask,
  output logic             irq
);
  logic [7:0] clr_vec, status_n, mask_n;

  always_comb begin
    clr_vec = clr_wr ? (wr_data & ISR_WCMASK) : 8'h00;
    if (clr_rst) clr_vec[IS_RST] = 1'b1;
    status_n = (status & ~clr_vec) | {1'b0, set_in};
    mask_n   = mask_wr ? wr_data : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= ISR_RESET;
      mask   <= 8'h00;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      mask   <= mask_n;
      irq    <= |(status_n & mask_n & ISR_WCMASK);
    end
  end
endmodule

// File: rtl/nicr_bank_regs.sv
module nicr_bank_regs
  import nicr_pkg::*;
#(
  parameter int         N_STA = 6,
  parameter int         N_MC  = 8,
  parameter logic [7:0] ID0   = 8'h50,
  parameter logic [7:0] ID1   = 8'h43,
  parameter logic [7:0] CFG0  = 8'h00,
  parameter logic [7:0] CFG2  = 8'h40,
  parameter logic [7:0] CFG3  = 8'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [3:0]         addr,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         cmd,
  input  logic [7:0]         isr,
  input  logic [7:0]         tsr,
  output logic               mask_wr,
  output logic               clr_wr,
  output logic [7:0]         rd_data,
  output logic [7:0]         ring_start,
  output logic [7:0]         ring_stop,
  output logic [7:0]         bnry_pg,
  output logic [7:0]         cur_pg,
  output logic [7:0]         tx_page,
  output logic [CNT_W-1:0]   tx_len,
  output logic [CNT_W-1:0]   rdma_addr,
  output logic [CNT_W-1:0]   rdma_cnt,
  output logic [7:0]         rcv_cfg,
  output logic [7:0]         data_cfg,
  output logic [8*N_STA-1:0] station_addr,
  output logic [8*N_MC-1:0]  mcast_filter
);
  logic [5:0] eff;
  logic       bw;
  logic [7:0] sta_q [N_STA];
  logic [7:0] mc_q  [N_MC];
  logic [7:0] rmux;

  assign eff     = {cmd[7:6], addr};
  assign bw      = wr_en && (addr != 4'h0);
  assign mask_wr = bw && (eff == A_IMR);
  assign clr_wr  = bw && (eff == A_ISR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_start <= '0; ring_stop <= '0; bnry_pg <= '0; cur_pg <= '0;
      tx_page    <= '0; tx_len    <= '0; rdma_addr <= '0; rdma_cnt <= '0;
      rcv_cfg    <= '0; data_cfg  <= '0;
    end else if (bw) begin
      case (eff)
        A_PSTART: ring_start       <= wr_data;
        A_PSTOP:  ring_stop        <= wr_data;
        A_BNRY:   bnry_pg          <= wr_data;
        A_CUR:    cur_pg           <= wr_data;
        A_TPG:    tx_page          <= wr_data;
        A_TCL:    tx_len[7:0]      <= wr_data;
        A_TCH:    tx_len[15:8]     <= wr_data;
        A_RSL:    rdma_addr[7:0]   <= wr_data;
        A_RSH:    rdma_addr[15:8]  <= wr_data;
        A_RCL:    rdma_cnt[7:0]    <= wr_data;
        A_RCH:    rdma_cnt[15:8]   <= wr_data;
        A_RXC:    rcv_cfg          <= wr_data;
        A_DCF:    data_cfg         <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_STA; i++) begin : g_sta
    always_ff @(posedge clk) begin
      if (rst) sta_q[i] <= '0;
      else if (bw && eff == A_STA + 6'(i)) sta_q[i] <= wr_data;
    end
    assign station_addr[8*i +: 8] = sta_q[i];
  end

  for (genvar i = 0; i < N_MC; i++) begin : g_mc
    always_ff @(posedge clk) begin
      if (rst) mc_q[i] <= '0;
      else if (bw && eff == A_MC + 6'(i)) mc_q[i] <= wr_data;
    end
    assign mcast_filter[8*i +: 8] = mc_q[i];
  end

  always_comb begin
    case (eff)
      A_BNRY:  rmux = bnry_pg;
      A_TPG:   rmux = tsr;
      A_ISR:   rmux = isr;
      A_RSL:   rmux = rdma_addr[7:0];
      A_RSH:   rmux = rdma_addr[15:8];
      A_RCL:   rmux = ID0;
      A_RCH:   rmux = ID1;
      A_CUR:   rmux = cur_pg;
      A_P2STA: rmux = ring_start;
      A_P2STP: rmux = ring_stop;
      A_CFG0:  rmux = CFG0;
      A_CFG2:  rmux = CFG2;
      A_CFG3:  rmux = CFG3;
      default: rmux = 8'h00;
    endcase
    for (int i = 0; i < N_STA; i++)
      if (eff == A_STA + 6'(i)) rmux = sta_q[i];
    for (int i = 0; i < N_MC; i++)
      if (eff == A_MC + 6'(i)) rmux = mc_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= (addr == 4'h0) ? cmd : rmux;
  end
endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs
  import nicr_pkg::*;
#(
  parameter int         N_STA = 6,
  parameter int         N_MC  = 8,
  parameter logic [7:0] ID0   = 8'h50,
  parameter logic [7:0] ID1   = 8'h43
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [3:0]         addr,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  input  logic [EVT_W-1:0]   evt_set,
  output logic               irq,
  output logic               tx_start,
  output logic [7:0]         tx_page,
  output logic [CNT_W-1:0]   tx_len,
  output logic [7:0]         ring_start,
  output logic [7:0]         ring_stop,
  output logic [7:0]         bnry_pg,
  output logic [7:0]         cur_pg,
  output logic [CNT_W-1:0]   rdma_addr,
  output logic [CNT_W-1:0]   rdma_cnt,
  output logic [7:0]         rcv_cfg,
  output logic [7:0]         data_cfg,
  output logic [8*N_STA-1:0] station_addr,
  output logic [8*N_MC-1:0]  mcast_filter
);
  logic [7:0]       cmd_q, isr_q, imr_q, tsr_q;
  logic             start_wr, zero_dma, mask_wr, clr_wr;
  logic [EVT_W-1:0] set_vec;

  always_comb begin
    set_vec = evt_set;
    if (tx_start_set) set_vec[IS_TX]  = 1'b1;
    if (zero_dma)     set_vec[IS_RDC] = 1'b1;
  end

  logic tx_start_set;
  assign tx_start_set = start_wr && wr_data[CMD_TXP];

  nicr_cmd_ctrl u_cmd (
    .clk(clk), .rst(rst), .cmd_wr(wr_en && addr == 4'h0), .wr_data(wr_data),
    .rcnt(rdma_cnt), .cmd(cmd_q), .start_wr(start_wr), .zero_dma(zero_dma),
    .tx_start(tx_start), .tsr(tsr_q)
  );

  nicr_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .clr_wr(clr_wr), .wr_data(wr_data),
    .set_in(set_vec), .clr_rst(start_wr), .status(isr_q), .mask(imr_q), .irq(irq)
  );

  nicr_bank_regs #(
    .N_STA(N_STA), .N_MC(N_MC), .ID0(ID0), .ID1(ID1)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .cmd(cmd_q), .isr(isr_q), .tsr(tsr_q),
    .mask_wr(mask_wr), .clr_wr(clr_wr), .rd_data(rd_data),
    .ring_start(ring_start), .ring_stop(ring_stop), .bnry_pg(bnry_pg),
    .cur_pg(cur_pg), .tx_page(tx_page), .tx_len(tx_len),
    .rdma_addr(rdma_addr), .rdma_cnt(rdma_cnt), .rcv_cfg(rcv_cfg),
    .data_cfg(data_cfg), .station_addr(station_addr), .mcast_filter(mcast_filter)
  );
endmodule

// File: rtl/nicr_chk.sv
module nicr_chk
  import nicr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [7:0]       wr_data,
  input logic [EVT_W-1:0] evt_set,
  input logic [CNT_W-1:0] rdma_cnt,
  input logic [7:0]       isr,
  input logic [7:0]       imr,
  input logic [7:0]       cmd,
  input logic             irq,
  input logic             tx_start
);
  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(isr & imr & 8'h7F)));

  // R7
  rst_bit_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(isr[7]));

  // R4
  start_clears_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'h0 && !wr_data[0]) |=> !isr[7]);

  // R5
  zero_dma_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'h0 && !wr_data[0] && (wr_data[3] || wr_data[4]) && rdma_cnt == '0)
    |=> isr[6]);

  // R6
  tx_done_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (isr[1] && !cmd[2]));

  // R10
  evt_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((isr[6:0] & $past(evt_set)) == $past(evt_set)));
endmodule

bind nic_page_regs nicr_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .evt_set(evt_set), .rdma_cnt(rdma_cnt), .isr(isr_q), .imr(imr_q),
  .cmd(cmd_q), .irq(irq), .tx_start(tx_start)
);

// File: tb/nic_page_regs_bench.sv
module nic_page_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [6:0]  evt_set = '0;
  logic [7:0]  rd_data, tx_page, ring_start, ring_stop, bnry_pg, cur_pg, rcv_cfg, data_cfg;
  logic [15:0] tx_len, rdma_addr, rdma_cnt;
  logic        irq, tx_start;
  logic [47:0] station_addr;
  logic [63:0] mcast_filter;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  nic_page_regs u_nic_page_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .evt_set(evt_set), .irq(irq),
    .tx_start(tx_start), .tx_page(tx_page), .tx_len(tx_len),
    .ring_start(ring_start), .ring_stop(ring_stop), .bnry_pg(bnry_pg),
    .cur_pg(cur_pg), .rdma_addr(rdma_addr), .rdma_cnt(rdma_cnt),
    .rcv_cfg(rcv_cfg), .data_cfg(data_cfg), .station_addr(station_addr),
    .mcast_filter(mcast_filter)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic pulse_evt(input logic [6:0] e);
    @(negedge clk); evt_set = e;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 tx_start", {15'd0, tx_start}, 16'd0);
    rd(4'h0, v); chk("R1 cmd", {8'd0, v}, 16'h01);
    rd(4'h7, v); chk("R1 isr", {8'd0, v}, 16'h80);
  endtask

  task automatic t_paging;
    logic [7:0] v;
    wr(4'h0, 8'h41); wr(4'h3, 8'hAA); wr(4'h7, 8'h4C);
    wr(4'h0, 8'h01); wr(4'h3, 8'h46); wr(4'h1, 8'h40); wr(4'h2, 8'h80);
    rd(4'h3, v); chk("R2 p0 bnry", {8'd0, v}, 16'h46);
    rd(4'h1, v); chk("R2 p0 read unmapped", {8'd0, v}, 16'h00);
    wr(4'h0, 8'h41);
    rd(4'h3, v); chk("R2 p1 station2", {8'd0, v}, 16'hAA);
    rd(4'h7, v); chk("R2 p1 cur", {8'd0, v}, 16'h4C);
    wr(4'h0, 8'h81);
    rd(4'h1, v); chk("R2 p2 start", {8'd0, v}, 16'h40);
    rd(4'h2, v); chk("R2 p2 stop", {8'd0, v}, 16'h80);
    chk("R2 station port", {8'd0, station_addr[23:16]}, 16'hAA);
    chk("R2 cur port", {8'd0, cur_pg}, 16'h4C);
    chk("R2 bnry port", {8'd0, bnry_pg}, 16'h46);
    chk("R2 ring ports", {ring_start, ring_stop}, 16'h4080);
  endtask

  task automatic t_split16;
    logic [7:0] v;
    wr(4'h0, 8'h01);
    wr(4'h5, 8'h34); wr(4'h6, 8'h12); chk("R3 tx_len", tx_len, 16'h1234);
    wr(4'h5, 8'hCD);                  chk("R3 tx_len lo only", tx_len, 16'h12CD);
    wr(4'h8, 8'h78); wr(4'h9, 8'h56); wr(4'h9, 8'h9A);
    rd(4'h8, v); chk("R3 rsar lo kept", {8'd0, v}, 16'h78);
    rd(4'h9, v); chk("R3 rsar hi", {8'd0, v}, 16'h9A);
    wr(4'hA, 8'h05); wr(4'hB, 8'h00); chk("R3 rcnt", rdma_cnt, 16'h0005);
  endtask

  task automatic t_fixed;
    logic [7:0] v;
    rd(4'hA, v); chk("R9 id0", {8'd0, v}, 16'h50);
    rd(4'hB, v); chk("R9 id1", {8'd0, v}, 16'h43);
    rd(4'hD, v); chk("R9 unmapped p0", {8'd0, v}, 16'h00);
    wr(4'h0, 8'hC1);
    rd(4'h3, v); chk("R9 cfg0", {8'd0, v}, 16'h00);
    rd(4'h5, v); chk("R9 cfg2", {8'd0, v}, 16'h40);
    rd(4'h6, v); chk("R9 cfg3", {8'd0, v}, 16'h40);
    rd(4'h4, v); chk("R9 unmapped p3", {8'd0, v}, 16'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(4'h0, 8'h01); wr(4'hF, 8'hFF);
    chk("R8 bit7 no irq", {15'd0, irq}, 16'd0);
    pulse_evt(7'h04);
    chk("R8 irq on event", {15'd0, irq}, 16'd1);
    rd(4'h7, v); chk("R10 evt bit2", {8'd0, v}, 16'h84);
    wr(4'hF, 8'h00); chk("R8 masked", {15'd0, irq}, 16'd0);
    wr(4'hF, 8'h04); chk("R8 unmasked", {15'd0, irq}, 16'd1);
    wr(4'h7, 8'h84);
    rd(4'h7, v); chk("R7 w1c keeps bit7", {8'd0, v}, 16'h80);
    chk("R8 irq after clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_start;
    logic [7:0] v;
    wr(4'h0, 8'h01); rd(4'h7, v); chk("R4 stop keeps bit7", {8'd0, v}, 16'h80);
    wr(4'h0, 8'h22); rd(4'h7, v); chk("R4 start clears bit7", {8'd0, v}, 16'h00);
  endtask

  task automatic t_dma;
    logic [7:0] v;
    wr(4'h0, 8'h0A); rd(4'h7, v); chk("R5 nonzero count", {8'd0, v}, 16'h00);
    wr(4'hA, 8'h00); chk("R5 count zero", rdma_cnt, 16'h0000);
    wr(4'h0, 8'h12); rd(4'h7, v); chk("R5 zero count done", {8'd0, v}, 16'h40);
    wr(4'h7, 8'h40);
    wr(4'h0, 8'h19); rd(4'h7, v); chk("R5 stopped no done", {8'd0, v}, 16'h00);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    wr(4'h4, 8'h40); wr(4'h5, 8'h3C); wr(4'h6, 8'h00);
    wr(4'h0, 8'h26);
    chk("R6 pulse", {15'd0, tx_start}, 16'd1);
    chk("R6 page", {8'd0, tx_page}, 16'h40);
    chk("R6 len", tx_len, 16'h003C);
    @(negedge clk); chk("R6 one cycle", {15'd0, tx_start}, 16'd0);
    rd(4'h0, v); chk("R6 cmd bit2 cleared", {8'd0, v}, 16'h22);
    rd(4'h4, v); chk("R6 tsr", {8'd0, v}, 16'h01);
    rd(4'h7, v); chk("R6 isr tx", {8'd0, v}, 16'h02);
    wr(4'h0, 8'h05);
    chk("R6 stopped no pulse", {15'd0, tx_start}, 16'd0);
    @(negedge clk); chk("R6 stopped no pulse later", {15'd0, tx_start}, 16'd0);
    rd(4'h0, v); chk("R6 stopped cmd kept", {8'd0, v}, 16'h05);
  endtask

  task automatic t_setwins;
    logic [7:0] v;
    @(negedge clk); wr_en = 1'b1; addr = 4'h7; wr_data = 8'h01; evt_set = 7'h01;
    @(negedge clk); wr_en = 1'b0; evt_set = '0;
    rd(4'h7, v); chk("R10 set wins", {8'd0, v}, 16'h03);
    pulse_evt(7'h40);
    rd(4'h7, v); chk("R10 evt bit6", {8'd0, v}, 16'h43);
  endtask

  task automatic t_rdhold;
    logic [7:0] v;
    wr(4'h7, 8'h7F);
    chk("R11 hold", {8'd0, rd_data}, 16'h43);
    rd(4'h7, v); chk("R11 refresh", {8'd0, v}, 16'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset; t_paging; t_split16; t_fixed; t_irq;
    t_start; t_dma; t_tx; t_setwins; t_rdhold;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule